// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four Static Memory

This block is a synchronous memory with a read data port and a separate write data port, both fed from one shared address bus. Each address names a location that holds four 18-bit words. A request moves those four words as one sequential burst, with two words in each input-clock period. The block runs in single-clock mode: the output clock is the input clock. The double-data-rate beats are modelled by one internal beat clock that runs at twice the input-clock rate, so every beat-clock edge carries one data word. The rising edge of the input clock falls on every second beat edge.

The input-clock periods take turns as read slots and write slots, and the first slot after reset is a read slot. A port select that is asserted in a slot of the other kind is dropped. Because of this, a second read request in the period straight after an accepted read is ignored, and the same holds for writes. While the read port is deselected, the data output is not driven. The high-impedance state is represented by an output-enable flag held low, with the data bus held at zero.

Top module: `qdr4_sram`

## Requirements
- R1: The array holds 2^ADDR_W locations of four 18-bit words each (ADDR_W is 17 for the full 128K-location array). A word that is written is returned unchanged by a later read of the same location and beat.
- R2: Within a burst, the beats move in the sub-address order 0, 1, 2, 3. The sub-address forms the two least-significant bits of the word index.
- R3: Beat edges are numbered from 0, where edge 0 is the first beat-clock rising edge after reset is released. An edge n with n mod 4 = 0 is the input-clock rise of a read slot, and an edge with n mod 4 = 2 is the input-clock rise of a write slot. Port selects and the address are sampled only on these two kinds of edge.
- R4: A read select (rps_n low) at a write-slot edge is ignored, including one in the period directly after an accepted read. A write select (wps_n low) at a read-slot edge is ignored and changes no stored data. If both selects are low at a write-slot edge, only the write is accepted.
- R5: For a write accepted at edge n, the data beats for sub-addresses 0, 1, 2 and 3 are sampled from d at edges n+2, n+3, n+4 and n+5.
- R6: For a read accepted at edge n, q carries the beats for sub-addresses 0, 1, 2 and 3 with q_oe high after edges n+2, n+3, n+4 and n+5. Reads accepted in successive read slots give back-to-back bursts with no gap.
- R7: bw_n[0] gates data bits 8:0 and bw_n[1] gates data bits 17:9. Each is active low and is sampled with its own data beat. A disabled byte leaves its stored bits unchanged.
- R8: Once a burst is in flight it always completes. After the edge that follows the last beat, when no further read was accepted, q_oe is low and q is zero.
- R9: A read returns the data of every write accepted before it. A write accepted in the write slot right after a read does not change the data that read returns, even at the same address.
- R10: While reset is held, and after it, until a read burst starts, q_oe is low and q is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the input-clock rate; rising edges only |
| rst_n | input | 1 | Asynchronous active-low reset |
| rps_n | input | 1 | Read port select, active low |
| wps_n | input | 1 | Write port select, active low |
| bw_n | input | BEAT_W/BYTE_W (2) | Per-byte write enables, active low, sampled per beat |
| addr | input | ADDR_W (8) | Shared read/write location address |
| d | input | BEAT_W (18) | Write data beat |
| q | output | BEAT_W (18) | Read data beat, zero when not driven |
| q_oe | output | 1 | High while q carries a read beat |

## Verification
The hardest case to reach from the ports is a read and a write to the same location whose bursts overlap in time. The point to check is which beats the read sees as old and which as new. The stimulus schedules a write to an address in the write slot straight after a read of that address, then a second read right behind it. This makes the first burst meet the incoming write beats on the same edges, while the second burst must return the merged data. Dropped requests are placed so that, if one were wrongly accepted, its burst would collide with a real burst or would drive q during a gap where the monitor expects q_oe low.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;

   // Position of a beat-clock edge within the read-slot / write-slot pair
   typedef enum logic [1:0] {
      RD_RISE = 2'd0,
      RD_FALL = 2'd1,
      WR_RISE = 2'd2,
      WR_FALL = 2'd3
   } beat_pos_e;

   localparam int BURST_LEN = 4;
   localparam int SUB_W     = $clog2(BURST_LEN);

endpackage

// File: rtl/qdr4_beat_seq.sv
module qdr4_beat_seq
   import qdr4_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   output beat_pos_e pos
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= RD_RISE;
      else        pos <= beat_pos_e'(2'(pos) + 2'd1);
   end

   // R3: the slot sequence always wraps from the write fall back to a read rise
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos == WR_FALL |=> pos == RD_RISE);

endmodule

// File: rtl/qdr4_burst_trk.sv
module qdr4_burst_trk
   import qdr4_pkg::*;
#(
   parameter int        ADDR_W = 8,
   parameter beat_pos_e SLOT   = RD_RISE,
   localparam int       IDX_W  = ADDR_W + SUB_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  beat_pos_e         pos,
   input  logic              sel_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              acc,
   output logic              beat_v,
   output logic [IDX_W-1:0]  beat_idx
);

   logic              pend_v, last_v;
   logic [ADDR_W-1:0] pend_a, last_a;
   logic [SUB_W-1:0]  sub;
   logic              use_last;

   assign acc = (pos == SLOT) && !sel_n;

   // Request and its copy kept for the final beat, both moved at the slot edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         last_v <= 1'b0;
         pend_a <= '0;
         last_a <= '0;
      end else if (pos == SLOT) begin
         pend_v <= !sel_n;
         pend_a <= addr;
         last_v <= pend_v;
         last_a <= pend_a;
      end
   end

   // Burst beats start two edges after the slot edge
   assign sub      = SUB_W'(2'(pos) - 2'(SLOT) - 2'd2);
   assign use_last = (sub == SUB_W'(BURST_LEN - 1));
   assign beat_v   = use_last ? last_v : pend_v;
   assign beat_idx = {(use_last ? last_a : pend_a), sub};

   // R5 / R6: an accepted request yields beat 0 two edges later
   acc_to_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ##2 (beat_v && beat_idx[SUB_W-1:0] == '0));

   // R2: beat 0 is followed by beat 1 of the same burst
   sub_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_v && beat_idx[SUB_W-1:0] == '0)
      |=> (beat_v && beat_idx[SUB_W-1:0] == SUB_W'(1)));

endmodule

// File: rtl/qdr4_lane_mem.sv
module qdr4_lane_mem #(
   parameter int  IDX_W  = 10,
   parameter int  LANE_W = 9,
   localparam int DEPTH  = 1 << IDX_W
)(
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [LANE_W-1:0] wdata,
   input  logic              re,
   input  logic [IDX_W-1:0]  ridx,
   output logic [LANE_W-1:0] rdata
);

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   // Registered read; the lane drives zero while the read port is idle
   always_ff @(posedge clk) begin
      rdata <= re ? mem[ridx] : '0;
   end

endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram
   import qdr4_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BEAT_W = 18,
   parameter int BYTE_W = 9
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rps_n,
   input  logic                       wps_n,
   input  logic [BEAT_W/BYTE_W-1:0]   bw_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [BEAT_W-1:0]          d,
   output logic [BEAT_W-1:0]          q,
   output logic                       q_oe
);

   localparam int NLANE = BEAT_W / BYTE_W;
   localparam int IDX_W = ADDR_W + SUB_W;

   if (ADDR_W < 1 || BYTE_W < 1 || BEAT_W % BYTE_W != 0) begin : g_bad_cfg
      $error("qdr4_sram: BEAT_W must be a whole number of BYTE_W lanes");
   end

   beat_pos_e         pos;
   logic              rd_acc, wr_acc;
   logic              rd_v, wr_v;
   logic [IDX_W-1:0]  rd_idx, wr_idx;

   qdr4_beat_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos)
   );

   qdr4_burst_trk #(.ADDR_W(ADDR_W), .SLOT(RD_RISE)) u_rd_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .pos      (pos),
      .sel_n    (rps_n),
      .addr     (addr),
      .acc      (rd_acc),
      .beat_v   (rd_v),
      .beat_idx (rd_idx)
   );

   qdr4_burst_trk #(.ADDR_W(ADDR_W), .SLOT(WR_RISE)) u_wr_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .pos      (pos),
      .sel_n    (wps_n),
      .addr     (addr),
      .acc      (wr_acc),
      .beat_v   (wr_v),
      .beat_idx (wr_idx)
   );

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      qdr4_lane_mem #(.IDX_W(IDX_W), .LANE_W(BYTE_W)) u_mem (
         .clk   (clk),
         .we    (wr_v && !bw_n[l]),
         .widx  (wr_idx),
         .wdata (d[l*BYTE_W +: BYTE_W]),
         .re    (rd_v),
         .ridx  (rd_idx),
         .rdata (q[l*BYTE_W +: BYTE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_oe <= 1'b0;
      else        q_oe <= rd_v;
   end

   // R6: the bus is enabled on the third edge seen after read acceptance
   rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |-> ##3 q_oe);

   // R8: an undriven bus carries zero
   q_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !q_oe |-> q == '0);

   // R8: the bus is released only at a write-slot rise, after a burst's last beat
   q_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q_oe) |-> pos == WR_FALL);

   // R4: a write-slot edge never accepts a read
   rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |-> !rd_acc);

endmodule

// File: tb/qdr4_sram_tb.sv
`timescale 1ns/100ps
module qdr4_sram_tb;

   localparam int AW = 8;
   localparam int NB = 160;   // beats played after reset

   typedef struct {
      int          beat;
      logic [17:0] data;
      int          req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rps_n = 1'b1, wps_n = 1'b1;
   logic [1:0]    bw_n = 2'b00;
   logic [AW-1:0] addr = '0;
   logic [17:0]   d = '0;
   logic [17:0]   q;
   logic          q_oe;

   always #2.5 clk = ~clk;

   qdr4_sram #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rps_n(rps_n), .wps_n(wps_n),
      .bw_n(bw_n), .addr(addr), .d(d), .q(q), .q_oe(q_oe)
   );

   // Stimulus schedule, one entry per beat edge
   logic          s_rps [NB+8];
   logic          s_wps [NB+8];
   logic [AW-1:0] s_addr[NB+8];
   logic [17:0]   s_d   [NB+8];
   logic [1:0]    s_bw  [NB+8];
   int            s_req [NB+8];

   logic [17:0] shadow [int];
   exp_t        expq[$];
   int          checks = 0, fails = 0;
   bit          done = 0;

   function automatic logic [17:0] pat(int seed, int k);
      return 18'(seed * 7919 + k * 1031 + 17);
   endfunction

   task automatic sched_wr(int kc, int a, int seed, logic [7:0] bw);
      int j = 2 * kc;
      s_wps[j]  = 1'b0;
      s_addr[j] = AW'(a);
      for (int k = 0; k < 4; k++) begin
         s_d[j+2+k]  = pat(seed, k);
         s_bw[j+2+k] = bw[2*k +: 2];
      end
   endtask

   task automatic sched_rd(int kc, int a, int req);
      s_rps[2*kc]  = 1'b0;
      s_addr[2*kc] = AW'(a);
      s_req[2*kc]  = req;
   endtask

   task automatic check(bit ok, int req, string what, logic [17:0] act, logic [17:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Driver: plays the schedule and predicts results from the requirements
   task automatic drive();
      for (int j = 0; j < NB; j++) begin
         @(negedge clk);
         if (j == 0) rst_n = 1'b1;
         rps_n = s_rps[j]; wps_n = s_wps[j]; addr = s_addr[j];
         d = s_d[j]; bw_n = s_bw[j];
         // R3/R4: write slots at j mod 4 == 2 (writes win), read slots at 0
         if (j % 4 == 2 && !s_wps[j]) begin
            for (int k = 0; k < 4; k++) begin
               int key = int'(s_addr[j]) * 4 + k;
               logic [17:0] v = shadow.exists(key) ? shadow[key] : 18'h0;
               // R7: bw_n[0] -> bits 8:0, bw_n[1] -> bits 17:9
               if (!s_bw[j+2+k][0]) v[8:0]  = s_d[j+2+k][8:0];
               if (!s_bw[j+2+k][1]) v[17:9] = s_d[j+2+k][17:9];
               shadow[key] = v;
            end
         end
         if (j % 4 == 0 && !s_rps[j]) begin
            for (int k = 0; k < 4; k++) begin
               exp_t e;
               e.beat = j + 2 + k;
               e.data = shadow[int'(s_addr[j]) * 4 + k];
               e.req  = s_req[j];
               expq.push_back(e);
            end
         end
      end
   endtask

   // Monitor: checks the outputs left by each beat edge
   task automatic monitor();
      @(posedge rst_n);
      for (int m = 0; m < NB - 1; m++) begin
         @(negedge clk);
         if (expq.size() > 0 && expq[0].beat == m) begin
            exp_t e = expq.pop_front();
            check(q_oe == 1'b1, 6, $sformatf("q_oe at beat %0d", m), 18'(q_oe), 18'h1);
            // R2: beat order within the burst, R1 stored data
            check(q == e.data, e.req, $sformatf("R2 data at beat %0d", m), q, e.data);
         end else begin
            // R8: idle bus
            check(q_oe == 1'b0 && q == 18'h0, 8, $sformatf("idle at beat %0d", m), q, 18'h0);
         end
      end
   endtask

   initial begin
      for (int j = 0; j < NB + 8; j++) begin
         s_rps[j] = 1'b1; s_wps[j] = 1'b1; s_addr[j] = AW'(j * 13);
         s_d[j] = 18'(j * 4099 + 3); s_bw[j] = 2'b00; s_req[j] = 1;
      end
      // R1/R5: fill four locations, including the top address
      sched_wr(1, 3, 1, 8'h00);
      sched_wr(3, 8'h55, 2, 8'h00);
      sched_wr(5, 8'hAA, 3, 8'h00);
      sched_wr(7, 8'hFF, 4, 8'h00);
      // R9: read at kc8, same-address write at kc9 must not leak into it
      sched_rd(8, 3, 9);
      // R7: per-beat byte masks {beat3,beat2,beat1,beat0}
      sched_wr(9, 3, 5, 8'b01_11_10_00);
      sched_rd(10, 3, 7);          // R9: sees merged write
      sched_rd(12, 8'h55, 6);      // R6: back-to-back with kc14
      s_rps[26] = 1'b0;            // R4: read right after read, write slot
      s_addr[26] = 8'hAA;
      sched_rd(14, 8'hAA, 6);
      // kc16 idle -> R8 release
      s_wps[36] = 1'b0;            // R4: write in read slot, ignored
      s_addr[36] = 8'hFF;
      for (int k = 0; k < 4; k++) s_d[38+k] = 18'h3FFFF;
      sched_wr(19, 8'h55, 6, 8'hFF);   // R7: all bytes disabled
      sched_rd(20, 8'hFF, 4);          // R4: unchanged
      sched_rd(22, 8'h55, 7);          // R7: unchanged
      sched_wr(25, 8'hAA, 8, 8'h00);   // R4: both selects in write slot
      s_rps[50] = 1'b0;
      sched_rd(26, 8'hAA, 4);
      s_rps[54] = 1'b0;                // R4: lone read in write slot
      s_addr[54] = 3;
      sched_rd(30, 3, 1);              // R1
      sched_rd(32, 0, 3);              // R3: first-slot check below
      sched_wr(33, 0, 9, 8'h00);
      sched_rd(34, 0, 5);              // R5
   end

   initial begin
      // R10: reset state
      #12;
      check(q_oe == 1'b0, 10, "q_oe in reset", 18'(q_oe), 18'h0);
      check(q == 18'h0, 10, "q in reset", q, 18'h0);
      fork
         drive();
         monitor();
      join
      check(expq.size() == 0, 6, "leftover expected beats", 18'(expq.size()), 18'h0);
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL R3 watchdog expired: actual %0d expected %0d", 0, 1);
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule